// File: doc/BRIEF.md
# Packed Signed Byte Adder

This unit performs a packed addition on two 32-bit operands, treating each as four independent signed 8-bit lanes. Every lane is added on its own with no carry crossing into its neighbour. The low 8 bits of each lane sum go to the same byte of the 32-bit result. Each lane also produces one greater-or-equal flag, taken from the sign of the exact 9-bit sum rather than from the wrapped byte.

An upstream decoder supplies a valid strobe, a condition-pass bit and three 4-bit register indices: one destination and two sources. The operands come from a register file that sits outside the unit. All outputs appear exactly one clock after the valid strobe, whatever the data. The unit returns write enables for the destination register and for the flag vector. It also raises an unpredictable indication when any of the three indices selects register 15.

Top module: `packed_sadd_unit`

## Requirements
- R1: For each lane i (bits 8i+7:8i), result_o lane i equals the low 8 bits of op_a_i lane i plus op_b_i lane i. No carry passes between lanes.
- R2: flags_o bit i is 1 when the exact signed sum of lane i is zero or positive, and 0 when it is negative. Lane 0 drives bit 0.
- R3: A lane that overflows upward (127 + 1) gives byte 0x80 with its flag set. A lane that overflows downward (-128 + -1) gives byte 0x7F with its flag clear.
- R4: unpredictable_o is 1 one cycle after an accepted valid_i when rd_idx_i, rn_idx_i or rm_idx_i equals 15. This holds whatever cond_pass_i is.
- R5: wr_en_o and flags_wr_en_o are 1 one cycle after valid_i only when cond_pass_i was 1 and no index was 15.
- R6: When cond_pass_i is 0 or the access is unpredictable, both write enables stay 0, so the destination and flag state are left unchanged.
- R7: valid_o follows valid_i by exactly one cycle for every operand value, condition and index.
- R8: While rst_ni is low, valid_o, wr_en_o, flags_wr_en_o, unpredictable_o, flags_o and result_o are all 0.
- R9: wr_idx_o carries the rd_idx_i of the operation accepted one cycle earlier.
- R10: A cycle with valid_i low produces no write enable and no unpredictable indication in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Decoded operation present |
| cond_pass_i | input | 1 | Condition check passed |
| rd_idx_i | input | 4 | Destination register index |
| rn_idx_i | input | 4 | First source register index |
| rm_idx_i | input | 4 | Second source register index |
| op_a_i | input | 32 | First source operand |
| op_b_i | input | 32 | Second source operand |
| valid_o | output | 1 | Operation completed |
| wr_en_o | output | 1 | Destination write enable |
| wr_idx_o | output | 4 | Destination register index |
| result_o | output | 32 | Packed lane sums |
| flags_o | output | 4 | Per-lane greater-or-equal flags |
| flags_wr_en_o | output | 1 | Flag vector write enable |
| unpredictable_o | output | 1 | Register 15 was named |

## Verification
The assertions assume that op_a_i and op_b_i are the register contents named by rn_idx_i and rm_idx_i in the same cycle as valid_i. They also assume that the inputs are stable around the clock edge. The bench meets both by driving every input on the falling edge, with the operands read from its own 16-entry register file model, and by updating that model only on a reported write. Random traffic mostly names indices 0 to 14 and occasionally 15, and it mixes in a failed condition and idle cycles. Directed cases add the four boundary pairs in every lane at once.

// File: rtl/packed_sadd_pkg.sv
package packed_sadd_pkg;
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned LANE_W_DEF = 8;
  localparam int unsigned IDX_W_DEF  = 4;
  localparam int unsigned BAD_IDX_DEF = 15;
endpackage

// File: rtl/sadd_lane.sv
module sadd_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         ge_o
);
  logic [W:0] wide;

  // one guard bit keeps the exact signed sum
  always_comb begin
    wide  = {a_i[W-1], a_i} + {b_i[W-1], b_i};
    sum_o = wide[W-1:0];
    ge_o  = ~wide[W];
  end
endmodule

// File: rtl/sadd_idx_chk.sv
module sadd_idx_chk #(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned BAD_IDX = 15,
  parameter int unsigned N_IDX   = 3
) (
  input  logic [N_IDX*IDX_W-1:0] idx_i,
  output logic                   bad_o
);
  localparam logic [IDX_W-1:0] BAD = IDX_W'(BAD_IDX);
  logic [N_IDX-1:0] hit;

  for (genvar k = 0; k < N_IDX; k++) begin : g_cmp
    assign hit[k] = (idx_i[k*IDX_W +: IDX_W] == BAD);
  end

  assign bad_o = |hit;
endmodule

// File: rtl/sadd_wb_reg.sv
module sadd_wb_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              cond_pass_i,
  input  logic              bad_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic [LANES-1:0]  ge_i,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic              flags_wr_en_o,
  output logic              unpred_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] sum_o,
  output logic [LANES-1:0]  ge_o
);
  logic commit;
  assign commit = valid_i & cond_pass_i & ~bad_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      wr_en_o       <= 1'b0;
      flags_wr_en_o <= 1'b0;
      unpred_o      <= 1'b0;
      idx_o         <= '0;
      sum_o         <= '0;
      ge_o          <= '0;
    end else begin
      valid_o       <= valid_i;
      wr_en_o       <= commit;
      flags_wr_en_o <= commit;
      unpred_o      <= valid_i & bad_i;
      if (valid_i) begin
        idx_o <= idx_i;
        sum_o <= sum_i;
        ge_o  <= ge_i;
      end
    end
  end
endmodule

// File: rtl/packed_sadd_unit.sv
module packed_sadd_unit
  import packed_sadd_pkg::*;
#(
  parameter int unsigned LANES   = LANES_DEF,
  parameter int unsigned LANE_W  = LANE_W_DEF,
  parameter int unsigned IDX_W   = IDX_W_DEF,
  parameter int unsigned BAD_IDX = BAD_IDX_DEF,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              cond_pass_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IDX_W-1:0]  rn_idx_i,
  input  logic [IDX_W-1:0]  rm_idx_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] result_o,
  output logic [LANES-1:0]  flags_o,
  output logic              flags_wr_en_o,
  output logic              unpredictable_o
);
  logic [DATA_W-1:0] sum_w;
  logic [LANES-1:0]  ge_w;
  logic              bad_w;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sadd_lane #(.W(LANE_W)) u_lane (
      .a_i  (op_a_i[l*LANE_W +: LANE_W]),
      .b_i  (op_b_i[l*LANE_W +: LANE_W]),
      .sum_o(sum_w[l*LANE_W +: LANE_W]),
      .ge_o (ge_w[l])
    );
  end

  sadd_idx_chk #(.IDX_W(IDX_W), .BAD_IDX(BAD_IDX), .N_IDX(3)) u_idx (
    .idx_i({rm_idx_i, rn_idx_i, rd_idx_i}),
    .bad_o(bad_w)
  );

  sadd_wb_reg #(.DATA_W(DATA_W), .LANES(LANES), .IDX_W(IDX_W)) u_wb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .cond_pass_i  (cond_pass_i),
    .bad_i        (bad_w),
    .idx_i        (rd_idx_i),
    .sum_i        (sum_w),
    .ge_i         (ge_w),
    .valid_o      (valid_o),
    .wr_en_o      (wr_en_o),
    .flags_wr_en_o(flags_wr_en_o),
    .unpred_o     (unpredictable_o),
    .idx_o        (wr_idx_o),
    .sum_o        (result_o),
    .ge_o         (flags_o)
  );
endmodule

// File: rtl/packed_sadd_chk.sv
module packed_sadd_chk #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned BAD_IDX = 15,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              cond_pass_i,
  input logic [IDX_W-1:0]  rd_idx_i,
  input logic [IDX_W-1:0]  rn_idx_i,
  input logic [IDX_W-1:0]  rm_idx_i,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic              valid_o,
  input logic              wr_en_o,
  input logic [IDX_W-1:0]  wr_idx_o,
  input logic [DATA_W-1:0] result_o,
  input logic [LANES-1:0]  flags_o,
  input logic              flags_wr_en_o,
  input logic              unpredictable_o
);
  localparam logic [IDX_W-1:0] BAD = IDX_W'(BAD_IDX);

  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> (!wr_en_o && !flags_wr_en_o && !unpredictable_o));

  p_cond_fail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && !$past(cond_pass_i)) |-> (!wr_en_o && !flags_wr_en_o));

  p_unpred_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && ($past(rd_idx_i) == BAD || $past(rn_idx_i) == BAD ||
                        $past(rm_idx_i) == BAD)) |-> (unpredictable_o && !wr_en_o));

  p_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (flags_wr_en_o && valid_o && !unpredictable_o));

  p_idx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) |-> (wr_idx_o == $past(rd_idx_i)));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    // same-sign inputs fix the flag regardless of wrap
    p_pos_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(valid_i) && !$past(op_a_i[l*LANE_W+LANE_W-1]) &&
       !$past(op_b_i[l*LANE_W+LANE_W-1])) |-> flags_o[l]);
    p_neg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(valid_i) && $past(op_a_i[l*LANE_W+LANE_W-1]) &&
       $past(op_b_i[l*LANE_W+LANE_W-1])) |-> !flags_o[l]);
    p_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(valid_i) |-> (result_o[l*LANE_W +: LANE_W] ==
        LANE_W'($past(op_a_i[l*LANE_W +: LANE_W]) + $past(op_b_i[l*LANE_W +: LANE_W]))));
  end
endmodule

bind packed_sadd_unit packed_sadd_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W), .BAD_IDX(BAD_IDX)
) u_chk (.*);

// File: tb/packed_sadd_unit_tb.sv
module packed_sadd_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        cond_pass_i = 1'b0;
  logic [3:0]  rd_idx_i = '0, rn_idx_i = '0, rm_idx_i = '0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic        valid_o, wr_en_o, flags_wr_en_o, unpredictable_o;
  logic [3:0]  wr_idx_o, flags_o;
  logic [31:0] result_o;

  logic [31:0] regs [16];
  logic [3:0]  ge_state = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  packed_sadd_unit u_dut (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [31:0] ref_sum(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) begin
      logic signed [8:0] s;
      s = 9'(signed'(a[l*8 +: 8])) + 9'(signed'(b[l*8 +: 8]));
      r[l*8 +: 8] = s[7:0];
    end
    return r;
  endfunction

  function automatic logic [3:0] ref_ge(input logic [31:0] a, input logic [31:0] b);
    logic [3:0] g;
    for (int l = 0; l < 4; l++) begin
      int s;
      s = int'(signed'(a[l*8 +: 8])) + int'(signed'(b[l*8 +: 8]));
      g[l] = (s >= 0);
    end
    return g;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // issue one op at negedge, check one negedge later
  task automatic run_op(input logic cond, input logic [3:0] d, input logic [3:0] n,
                        input logic [3:0] m);
    logic bad, commit;
    logic [31:0] a, b;
    a = regs[n]; b = regs[m];
    @(negedge clk_i);
    valid_i = 1; cond_pass_i = cond; rd_idx_i = d; rn_idx_i = n; rm_idx_i = m;
    op_a_i = a; op_b_i = b;
    @(negedge clk_i);
    valid_i = 0;
    bad = (d == 15) || (n == 15) || (m == 15);
    commit = cond && !bad;
    chk("R7 valid", 32'(valid_o), 32'd1);
    chk("R4 unpredictable", 32'(unpredictable_o), 32'(bad));
    chk("R5/R6 wr_en", 32'(wr_en_o), 32'(commit));
    chk("R5/R6 flags_wr_en", 32'(flags_wr_en_o), 32'(commit));
    chk("R9 wr_idx", 32'(wr_idx_o), 32'(d));
    chk("R1 result", result_o, ref_sum(a, b));
    chk("R2 flags", 32'(flags_o), 32'(ref_ge(a, b)));
    if (wr_en_o) regs[wr_idx_o] = result_o;
    if (flags_wr_en_o) ge_state = flags_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'h5add_0008));
    for (int k = 0; k < 16; k++) regs[k] = $urandom;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk("R8 reset outputs", {valid_o, wr_en_o, flags_wr_en_o, unpredictable_o, flags_o},
        8'h00);
    chk("R8 reset result", result_o, 32'h0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R10 idle", 32'({wr_en_o, flags_wr_en_o, unpredictable_o, valid_o}), 32'h0);

    // R3 boundaries in all lanes
    regs[1] = 32'h7F7F7F7F; regs[2] = 32'h01010101;
    run_op(1, 3, 1, 2);
    chk("R3 up overflow", {result_o, 28'(0)} == 60'h0 ? 32'h0 : result_o, 32'h80808080);
    chk("R3 up flags", 32'(flags_o), 32'hF);
    regs[1] = 32'h80808080; regs[2] = 32'hFFFFFFFF;
    run_op(1, 3, 1, 2);
    chk("R3 down overflow", result_o, 32'h7F7F7F7F);
    chk("R3 down flags", 32'(flags_o), 32'h0);
    regs[2] = 32'h7F7F7F7F;
    run_op(1, 3, 1, 2);
    chk("R2 minus one", result_o, 32'hFFFFFFFF);
    chk("R2 minus one flags", 32'(flags_o), 32'h0);
    regs[1] = 32'h0; regs[2] = 32'h0;
    run_op(1, 3, 1, 2);
    chk("R2 zero flags", 32'(flags_o), 32'hF);
    // mixed lanes, lane 0 -> bit 0: lanes 3..0 = 0+0, -128+-1, 127+1, -2+1
    regs[1] = 32'h00807FFE; regs[2] = 32'h00FF0101;
    run_op(1, 4, 1, 2);
    chk("R1 no carry", result_o, 32'h007F80FF);
    chk("R2 lane order", 32'(flags_o), 32'b1010);

    // R6 condition fail leaves destination unchanged
    keep = regs[5];
    run_op(0, 5, 1, 2);
    chk("R6 dest kept", regs[5], keep);
    // R4 register 15 in each slot, both condition values
    run_op(1, 15, 1, 2);
    run_op(1, 6, 15, 2);
    run_op(0, 6, 1, 15);

    for (int t = 0; t < 400; t++) begin
      logic [3:0] d, n, m;
      d = 4'($urandom_range(0, 14)); n = 4'($urandom_range(0, 14));
      m = 4'($urandom_range(0, 14));
      if ($urandom_range(0, 15) == 0) d = 15;
      if ($urandom_range(0, 15) == 0) n = 15;
      if ($urandom_range(0, 7) == 0) regs[n] = {4{8'($urandom_range(0, 1) ? 8'h80 : 8'h7F)}};
      run_op(1'($urandom_range(0, 4) != 0), d, n, m);
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk_i);
        chk("R10 gap", 32'({wr_en_o, flags_wr_en_o, unpredictable_o, valid_o}), 32'h0);
      end
    end
    summary();
  end
endmodule